// File: doc/BRIEF.md
# Single-Cycle Jump-and-Link RV32I Core

This block is a small RV32I subset processor that completes one instruction on every rising clock edge. It supports register-to-register add, sub, and and or, along with addi, lw, sw, beq, lui, jal and jalr. The core fetches from an instruction memory through a combinational read port. It reaches data memory through a word-wide port with address, write data, write enable and read data. Both memories live outside the core.

The core contains the program counter, a 32-entry register file, the immediate generator, the ALU, the decoder and the writeback and next-PC selectors. Two independent select bits drive the writeback selector, which picks among the ALU result, loaded data, the immediate and the return address. Jumps override the branch comparison. The return address is the PC+4 of the jumping instruction itself. The register-file write and the PC update share one clock edge, so this value is formed before the PC changes.

Top module: `jl_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and every register to 0. `dmem_we` stays low while reset is asserted.
- R2: R-type instructions use opcode 0110011. The operations are add (funct3 000, funct7 0000000), sub (funct3 000, funct7 0100000), and (funct3 111) and or (funct3 110). addi uses opcode 0010011, funct3 000, and sign-extends its immediate from bits 31:20. All results wrap modulo 2^32.
- R3: sw (opcode 0100011, funct3 010) writes rs2 to the byte address rs1 + sign-extended {inst[31:25], inst[11:7]}. lw (opcode 0000011, funct3 010) loads rd from rs1 + sign-extended inst[31:20]. `dmem_we` is high only for sw.
- R4: beq (opcode 1100011, funct3 000) moves the PC to PC + sign-extended {inst[31], inst[7], inst[30:25], inst[11:8], 0} when rs1 equals rs2. Otherwise the PC moves to PC+4. Backward offsets are supported.
- R5: lui (opcode 0110111) writes inst[31:12] into bits 31:12 of rd and clears bits 11:0 of rd, whatever rd held before.
- R6: jal (opcode 1101111) always sets the next PC to PC + sign-extended {inst[31], inst[19:12], inst[20], inst[30:21], 0}. It writes its own PC+4 into rd.
- R7: jalr (opcode 1100111, funct3 000) sets the next PC to (rs1 + sign-extended inst[31:20]) with bit 0 cleared, and writes its own PC+4 into rd. When rd equals rs1, the target uses the value rs1 held before the write.
- R8: Register x0 always reads as zero, and writes to it are dropped. jal or jalr with rd = x0 is a plain jump.
- R9: Every instruction other than beq, jal and jalr advances the PC by 4. The PC appears directly on `imem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address of the load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written at the next rising edge |
| dmem_rdata | input | 32 | Word read combinationally at `dmem_addr` |

## Verification
The embedded properties assume that `imem_data` always holds a defined, supported encoding once reset is released. They also assume that control-transfer targets are word-aligned addresses that the memory model can serve. The stimulus keeps to these limits in three ways. Every program is assembled by encoder functions. Unused words are filled with addi x0, x0, 0. Each jump, branch and jalr target is chosen inside a 64-word instruction array, and each program ends in a self-loop. The odd jalr sums are set up on purpose so that bit 0 clearing still yields an aligned target.

// File: rtl/jl_core.sv
`timescale 1ns/1ps
module jl_core (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  localparam logic [6:0] OP_R    = 7'b0110011;
  localparam logic [6:0] OP_I    = 7'b0010011;
  localparam logic [6:0] OP_LD   = 7'b0000011;
  localparam logic [6:0] OP_ST   = 7'b0100011;
  localparam logic [6:0] OP_BR   = 7'b1100011;
  localparam logic [6:0] OP_LUI  = 7'b0110111;
  localparam logic [6:0] OP_JAL  = 7'b1101111;
  localparam logic [6:0] OP_JALR = 7'b1100111;

  typedef enum logic [2:0] {IMM_I, IMM_S, IMM_B, IMM_U, IMM_J} imm_kind_t;

  logic [31:0] pc, pc_next, inst;
  logic [31:0] rf [0:31];
  logic [6:0]  opcode;
  logic [4:0]  rd, rs1, rs2;
  logic [2:0]  f3;
  logic [31:0] imm_i, imm_s, imm_b, imm_u, imm_j, imm;
  logic [31:0] rs1v, rs2v, alu_b, alu_y, wb, link;
  logic        reg_write, mem_sel, imm_sel, alu_src, branch, jump, jreg, mem_write, alu_rtype, take;
  imm_kind_t   kind;

  assign inst      = imem_data;
  assign imem_addr = pc;
  assign opcode    = inst[6:0];
  assign rd        = inst[11:7];
  assign f3        = inst[14:12];
  assign rs1       = inst[19:15];
  assign rs2       = inst[24:20];

  assign imm_i = {{20{inst[31]}}, inst[31:20]};
  assign imm_s = {{20{inst[31]}}, inst[31:25], inst[11:7]};
  assign imm_b = {{19{inst[31]}}, inst[31], inst[7], inst[30:25], inst[11:8], 1'b0};
  assign imm_u = {inst[31:12], 12'b0};
  assign imm_j = {{11{inst[31]}}, inst[31], inst[19:12], inst[20], inst[30:21], 1'b0};

  always_comb begin
    reg_write = 1'b0; mem_sel = 1'b0; imm_sel = 1'b0; alu_src = 1'b0;
    branch = 1'b0; jump = 1'b0; jreg = 1'b0; mem_write = 1'b0; alu_rtype = 1'b0;
    kind = IMM_I;
    case (opcode)
      OP_R:    begin reg_write = 1'b1; alu_rtype = 1'b1; end
      OP_I:    begin reg_write = 1'b1; alu_src = 1'b1; end
      OP_LD:   begin reg_write = 1'b1; alu_src = 1'b1; mem_sel = 1'b1; end
      OP_ST:   begin alu_src = 1'b1; mem_write = 1'b1; kind = IMM_S; end
      OP_BR:   begin branch = 1'b1; kind = IMM_B; end
      OP_LUI:  begin reg_write = 1'b1; imm_sel = 1'b1; kind = IMM_U; end
      OP_JAL:  begin reg_write = 1'b1; jump = 1'b1; imm_sel = 1'b1; mem_sel = 1'b1; kind = IMM_J; end
      OP_JALR: begin reg_write = 1'b1; jreg = 1'b1; alu_src = 1'b1; imm_sel = 1'b1; mem_sel = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    case (kind)
      IMM_S:   imm = imm_s;
      IMM_B:   imm = imm_b;
      IMM_U:   imm = imm_u;
      IMM_J:   imm = imm_j;
      default: imm = imm_i;
    endcase
  end

  assign rs1v  = rf[rs1];
  assign rs2v  = rf[rs2];
  assign alu_b = alu_src ? imm : rs2v;

  always_comb begin
    alu_y = rs1v + alu_b;
    if (alu_rtype)
      case (f3)
        3'b000:  alu_y = inst[30] ? rs1v - alu_b : rs1v + alu_b;
        3'b111:  alu_y = rs1v & alu_b;
        3'b110:  alu_y = rs1v | alu_b;
        default: alu_y = rs1v + alu_b;
      endcase
  end

  assign link = pc + 32'd4;
  assign take = jump | (branch & (rs1v == rs2v));
  assign pc_next = jreg ? {alu_y[31:1], 1'b0} : (take ? pc + imm : link);

  always_comb begin
    case ({imm_sel, mem_sel})
      2'b01:   wb = dmem_rdata;
      2'b10:   wb = imm;
      2'b11:   wb = link;
      default: wb = alu_y;
    endcase
  end

  assign dmem_addr  = alu_y;
  assign dmem_wdata = rs2v;
  assign dmem_we    = mem_write & ~rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= 32'd0;
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else begin
      pc <= pc_next;
      if (reg_write && rd != 5'd0) rf[rd] <= wb;
    end
  end

  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> pc == 32'd0);
  // R9
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_R || opcode == OP_I || opcode == OP_LD || opcode == OP_ST || opcode == OP_LUI)
    |=> pc == $past(pc) + 32'd4);
  // R4
  beq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    opcode == OP_BR |=> pc == ($past(rs1v == rs2v) ? $past(pc + imm_b) : $past(pc) + 32'd4));
  // R6
  jal_pc_chk: assert property (@(posedge clk) disable iff (rst)
    opcode == OP_JAL |=> pc == $past(pc + imm_j));
  // R6
  jal_link_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_JAL && rd != 5'd0) |=> rf[$past(rd)] == $past(pc) + 32'd4);
  // R7
  jalr_pc_chk: assert property (@(posedge clk) disable iff (rst)
    opcode == OP_JALR |=> (pc[0] == 1'b0 && pc == ($past(rs1v + imm_i) & ~32'd1)));
  // R3
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> opcode == OP_ST);
endmodule

// File: tb/test_jl_core.sv
`timescale 1ns/1ps
module test_jl_core;
  logic clk = 1'b0, rst = 1'b1, clr = 1'b1;
  always #2 clk = ~clk;

  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [31:0] imem [0:63];
  logic [31:0] dmem [0:63];
  int vectors = 0, fails = 0, nstores = 0;

  localparam logic [31:0] NOP  = 32'h00000013;
  localparam logic [31:0] SENT = 32'hA5A5A5A5;

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 64; i++) dmem[i] <= SENT;
      nstores <= 0;
    end else if (dmem_we) begin
      dmem[dmem_addr[7:2]] <= dmem_wdata;
      nstores <= nstores + 1;
    end
  end

  jl_core i_jl_core (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  function automatic logic [31:0] e_r(input logic [6:0] f7, input int rs2, input int rs1,
                                      input logic [2:0] f3, input int rd);
    return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'b0110011};
  endfunction
  function automatic logic [31:0] e_i(input int imm, input int rs1, input int rd, input logic [6:0] op,
                                      input logic [2:0] f3);
    logic [11:0] v = 12'(imm);
    return {v, 5'(rs1), f3, 5'(rd), op};
  endfunction
  function automatic logic [31:0] e_s(input int imm, input int rs2, input int rs1);
    logic [11:0] v = 12'(imm);
    return {v[11:5], 5'(rs2), 5'(rs1), 3'b010, v[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] e_b(input int imm, input int rs2, input int rs1);
    logic [12:0] v = 13'(imm);
    return {v[12], v[10:5], 5'(rs2), 5'(rs1), 3'b000, v[4:1], v[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] e_u(input int imm20, input int rd);
    return {20'(imm20), 5'(rd), 7'b0110111};
  endfunction
  function automatic logic [31:0] e_j(input int imm, input int rd);
    logic [20:0] v = 21'(imm);
    return {v[20], v[10:1], v[11], v[19:12], 5'(rd), 7'b1101111};
  endfunction
  function automatic logic [31:0] addi(input int rd, input int rs1, input int imm);
    return e_i(imm, rs1, rd, 7'b0010011, 3'b000);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) imem[i] = NOP;
  endtask

  task automatic boot();
    @(negedge clk); rst = 1'b1; clr = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0; clr = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  int av [8] = '{0, 1, -1, 2047, -2048, 100, -7, 1365};
  int bv [4] = '{0, 5, -5, 5};
  int ks [2] = '{10, 20};
  int ts [8] = '{2, 5, 13, 16, 25, 33, 47, 61};
  int js [6] = '{3, 7, 16, 33, 50, 62};

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    clear_prog();

    // R2 R3 R9: ALU sweep over operand pairs
    foreach (av[a]) foreach (av[b]) begin
      clear_prog();
      imem[0] = addi(1, 0, av[a]);
      imem[1] = addi(2, 0, av[b]);
      imem[2] = e_r(7'b0000000, 2, 1, 3'b000, 3);
      imem[3] = e_r(7'b0100000, 2, 1, 3'b000, 4);
      imem[4] = e_r(7'b0000000, 2, 1, 3'b111, 5);
      imem[5] = e_r(7'b0000000, 2, 1, 3'b110, 6);
      imem[6] = e_s(0, 3, 0);
      imem[7] = e_s(4, 4, 0);
      imem[8] = e_s(8, 5, 0);
      imem[9] = e_s(12, 6, 0);
      imem[10] = e_j(0, 0);
      boot();
      run(12);
      chk("R2 add", dmem[0], 32'(av[a] + av[b]));
      chk("R2 sub", dmem[1], 32'(av[a] - av[b]));
      chk("R2 and", dmem[2], 32'(av[a] & av[b]));
      chk("R2 or",  dmem[3], 32'(av[a] | av[b]));
      chk("R9 pc",  imem_addr, 32'd40);
      chk("R3 store count", 32'(nstores), 32'd4);
    end

    // R3: store, load back, store again with a negative offset
    foreach (av[a]) begin
      clear_prog();
      imem[0] = addi(1, 0, av[a]);
      imem[1] = addi(3, 0, 64);
      imem[2] = e_s(-8, 1, 3);
      imem[3] = e_i(-8, 3, 2, 7'b0000011, 3'b010);
      imem[4] = e_s(24, 2, 0);
      imem[5] = e_j(0, 0);
      boot();
      run(7);
      chk("R3 sw", dmem[14], 32'(av[a]));
      chk("R3 lw", dmem[6], 32'(av[a]));
      chk("R3 we count", 32'(nstores), 32'd2);
    end

    // R5 R8: lui sweep over upper immediates
    for (int i = 0; i < 16; i++) begin
      int u;
      u = ((i * 69905) ^ (i << 16) ^ ((i & 1) << 19)) & 32'hFFFFF;
      clear_prog();
      imem[0] = addi(1, 0, -1);
      imem[1] = e_u(u, 1);
      imem[2] = e_s(0, 1, 0);
      imem[3] = e_u(u, 0);
      imem[4] = e_s(4, 0, 0);
      imem[5] = e_j(0, 0);
      boot();
      run(7);
      chk("R5 lui", dmem[0], 32'(u) << 12);
      chk("R8 lui x0", dmem[1], 32'd0);
    end

    // R4: beq taken and not taken
    foreach (bv[a]) foreach (bv[b]) begin
      bit eq;
      eq = (bv[a] == bv[b]);
      clear_prog();
      imem[0] = addi(1, 0, bv[a]);
      imem[1] = addi(2, 0, bv[b]);
      imem[2] = e_b(12, 2, 1);
      imem[3] = addi(3, 0, 1);
      imem[4] = addi(4, 0, 2);
      imem[5] = e_s(0, 3, 0);
      imem[6] = e_s(4, 4, 0);
      imem[7] = e_j(0, 0);
      boot();
      run(3);
      chk("R4 beq pc", imem_addr, eq ? 32'd20 : 32'd12);
      run(5);
      chk("R4 beq skip x3", dmem[0], eq ? 32'd0 : 32'd1);
      chk("R4 beq skip x4", dmem[1], eq ? 32'd0 : 32'd2);
    end

    // R4: backward branch
    clear_prog();
    imem[0] = e_j(16, 0);
    imem[1] = addi(3, 0, 9);
    imem[2] = e_s(0, 3, 0);
    imem[3] = e_j(0, 0);
    imem[4] = e_b(-12, 0, 0);
    boot();
    run(2);
    chk("R4 backward pc", imem_addr, 32'd4);
    run(4);
    chk("R4 backward path", dmem[0], 32'd9);

    // R6 R8: jal forward and backward with link
    foreach (ks[k]) foreach (ts[t]) begin
      if (!(ts[t] <= ks[k] && ts[t] + 2 >= ks[k])) begin
        clear_prog();
        imem[0] = e_j(ks[k] * 4, 0);
        imem[ks[k]] = e_j((ts[t] - ks[k]) * 4, 5);
        imem[ts[t]] = e_s(0, 5, 0);
        imem[ts[t] + 1] = e_s(4, 0, 0);
        imem[ts[t] + 2] = e_j(0, 0);
        boot();
        run(1);
        chk("R8 jal x0 plain jump", imem_addr, 32'(ks[k] * 4));
        run(1);
        chk("R6 jal target", imem_addr, 32'(ts[t] * 4));
        run(3);
        chk("R6 jal link", dmem[0], 32'(ks[k] * 4 + 4));
        chk("R8 x0 unlinked", dmem[1], 32'd0);
      end
    end

    // R7: jalr with odd sum, separate rd and rd equal to rs1
    foreach (js[t]) for (int v = 0; v < 2; v++) begin
      int rd, imm, base;
      rd = (v == 0) ? 6 : 1;
      imm = (v == 0) ? 5 : -3;
      base = js[t] * 4 + 1 - imm;
      clear_prog();
      imem[0] = addi(1, 0, base);
      imem[1] = e_i(imm, 1, rd, 7'b1100111, 3'b000);
      imem[js[t]] = e_s(0, rd, 0);
      imem[js[t] + 1] = e_j(0, 0);
      boot();
      run(2);
      chk("R7 jalr target", imem_addr, 32'(js[t] * 4));
      run(3);
      chk("R7 jalr link", dmem[0], 32'd8);
    end

    // R1 R8: reset clears PC and registers left from earlier runs
    clear_prog();
    imem[0] = addi(0, 0, 5);
    imem[1] = e_s(0, 0, 0);
    imem[2] = e_s(4, 1, 0);
    imem[3] = e_s(8, 3, 0);
    imem[4] = e_s(12, 5, 0);
    imem[5] = e_s(16, 6, 0);
    imem[6] = e_j(0, 0);
    @(negedge clk); rst = 1'b1; clr = 1'b1;
    @(negedge clk);
    chk("R1 reset pc", imem_addr, 32'd0);
    chk("R1 no store in reset", {31'd0, dmem_we}, 32'd0);
    @(negedge clk); rst = 1'b0; clr = 1'b0;
    run(8);
    chk("R8 addi x0", dmem[0], 32'd0);
    chk("R1 x1 cleared", dmem[1], 32'd0);
    chk("R1 x3 cleared", dmem[2], 32'd0);
    chk("R1 x5 cleared", dmem[3], 32'd0);
    chk("R1 x6 cleared", dmem[4], 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule